// File: doc/BRIEF.md
# Ethernet Pause Flow Control Unit

This unit handles MAC Control pause operation for an Ethernet MAC with an 8-bit byte datapath, in both directions. On the transmit side, the client raises a one-cycle request together with a 16-bit pause time. The unit holds that request until the MAC's own frame in flight has finished. It then offers a complete pause frame, without FCS, to the downstream framer on a valid/ready byte stream.

On the receive side, the unit watches the received byte stream alongside the normal receive path. When it finds a well-formed pause frame with a good FCS that is addressed to the reserved control multicast address or to the station address, it does two things. It raises a one-cycle flag that tells the receive path to mark the frame bad, so that the client drops it. It also holds off the transmitter for the requested number of pause quanta. Transmit handling and receive handling each have their own enable, and both enables come out of reset set.

Back-pressure rules on the outgoing stream: a byte moves only in a cycle where `pf_valid` and `pf_ready` are both high. While `pf_valid` is high and `pf_ready` is low, `pf_data` and `pf_last` hold their values. Once a frame has started, it runs to its last byte whatever `tx_busy` does. The receive input is an observe-only tap and never back-pressures the receive path.

Top module: `fc_pause_unit`

## Requirements
- R1: After reset, `pf_valid`, `tx_inhibit` and `rx_pause_bad` are low, and both direction enables are 1.
- R2: With transmit handling enabled, a request produces exactly 60 bytes, with `pf_last` high on the 60th byte only. The bytes are, in order:
  - DA: 01 80 C2 00 00 01.
  - SA: the six bytes of `station_addr`, least significant byte first (0xFFEEDDCCBBAA is sent as AA BB CC DD EE FF).
  - Type: 88 08.
  - Opcode: 00 01.
  - Pause time: most significant byte first.
  - Zero padding up to byte 60.
- R3: A pending request does not start its frame while `tx_busy` is high. The frame starts after `tx_busy` falls.
- R4: While `pf_valid` is high and `pf_ready` is low, `pf_valid`, `pf_data` and `pf_last` are held on the next cycle.
- R5: A received frame is accepted as a pause frame only when all of the following hold:
  - its DA matches 01-80-C2-00-00-01 or the station address (least significant byte first on the wire);
  - bytes 12-13 are 88 08;
  - bytes 14-15 are 00 01;
  - it has at least 18 bytes;
  - `rx_fcs_ok` is high with the last byte.

  An accepted frame raises `rx_pause_bad` for exactly the one cycle after the last byte.
- R6: An accepted pause time V (bytes 16-17, most significant byte first) raises `tx_inhibit` from the cycle after the last byte, for exactly V×QUANTUM_CYC cycles (64 by default).
- R7: A new accepted pause frame reloads the remaining time with its own value. The new value replaces the remaining time and is not added to it.
- R8: An accepted pause time of zero ends any pause in progress on the next cycle. The frame is still flagged.
- R9: With receive handling disabled, pause frames raise neither `rx_pause_bad` nor `tx_inhibit`.
- R10: With transmit handling disabled, `pause_req` has no effect and no frame is offered.
- R11: A `cfg_we` pulse loads both enables from `cfg_tx_fc_en` and `cfg_rx_fc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the two enables |
| cfg_tx_fc_en | input | 1 | New transmit-side enable |
| cfg_rx_fc_en | input | 1 | New receive-side enable |
| station_addr | input | 48 | Station address, first wire byte in bits 7:0 |
| pause_req | input | 1 | One-cycle pause frame request |
| pause_val | input | 16 | Pause time sent with the request |
| tx_busy | input | 1 | A client frame is being transmitted |
| pf_valid | output | 1 | Pause frame byte available |
| pf_ready | input | 1 | Framer accepts the byte |
| pf_data | output | 8 | Pause frame byte |
| pf_last | output | 1 | Final byte of the pause frame |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Final byte of the received frame |
| rx_fcs_ok | input | 1 | FCS result, meaningful with rx_last |
| rx_pause_bad | output | 1 | Consumed pause frame; mark it bad |
| tx_inhibit | output | 1 | Hold off the transmitter |

## Verification
A corrupt pause counter or quantum divider shows up as a `tx_inhibit` window whose length differs from V×64 cycles; the bench measures that window to the cycle. A header matcher that keeps stale state from an earlier frame shows up within one frame: a rejected frame gets flagged, or an accepted frame does not. A wrong byte index or a lost handshake in the generator shows up as a wrong, duplicated or skipped byte, or as a misplaced `pf_last`, within the 60 bytes of a single pause frame.

// File: rtl/fc_pause_pkg.sv
package fc_pause_pkg;
  localparam int VAL_W = 16;
  localparam logic [47:0] CTRL_MCAST = 48'h01_00_00_C2_80_01;
  localparam logic [15:0] MAC_CTRL_TYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE = 16'h0001;
  localparam int HDR_BYTES = 18;

  typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;

  // Byte at wire position idx of a pause frame header; zero past the header.
  function automatic logic [7:0] hdr_byte(input logic [5:0] idx, input logic [47:0] da,
                                          input logic [47:0] sa, input logic [VAL_W-1:0] val);
    logic [8*HDR_BYTES-1:0] h;
    logic [7:0] b;
    h = {val[7:0], val[15:8], PAUSE_OPCODE[7:0], PAUSE_OPCODE[15:8],
         MAC_CTRL_TYPE[7:0], MAC_CTRL_TYPE[15:8], sa, da};
    b = 8'h00;
    if (int'(idx) < HDR_BYTES) b = h[8*int'(idx) +: 8];
    return b;
  endfunction
endpackage

// File: rtl/fc_pause_timer.sv
module fc_pause_timer
  import fc_pause_pkg::*;
#(
  parameter int QUANTUM_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VAL_W-1:0] load_val,
  output logic             inhibit
);
  localparam int SUB_W = (QUANTUM_CYC > 1) ? $clog2(QUANTUM_CYC) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(QUANTUM_CYC - 1);

  logic [VAL_W-1:0] quanta;
  logic [SUB_W-1:0] sub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quanta <= '0;
      sub    <= '0;
    end else if (load) begin
      quanta <= load_val;
      sub    <= '0;
    end else if (quanta != '0) begin
      if (sub == SUB_LAST) begin
        sub    <= '0;
        quanta <= quanta - 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign inhibit = (quanta != '0);

  // R6: without a load the remaining time never grows
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> quanta <= $past(quanta));
  // R8: a zero load ends the pause on the next cycle
  p_zero_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> !inhibit);
endmodule

// File: rtl/fc_pause_rx.sv
module fc_pause_rx
  import fc_pause_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [47:0]      station_addr,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic             rx_fcs_ok,
  output logic             accept,
  output logic [VAL_W-1:0] accept_val,
  output logic             pause_bad
);
  localparam logic [4:0] IDX_SAT = 5'(HDR_BYTES);

  logic [4:0] idx;
  logic       mc_ok, st_ok, ctl_ok;
  logic [7:0] val_hi, val_lo;
  logic       first, mc_c, st_c, ctl_c, in_da, in_ctl;
  logic [7:0] mc_b, st_b, vh_c, vl_c;

  always_comb begin
    first  = (idx == '0);
    in_da  = (idx < 5'd6);
    in_ctl = (idx >= 5'd12) && (idx <= 5'd15);
    mc_b   = hdr_byte({1'b0, idx}, CTRL_MCAST, 48'h0, '0);
    st_b   = hdr_byte({1'b0, idx}, station_addr, 48'h0, '0);
    mc_c   = (first | mc_ok) & (!in_da | (rx_data == mc_b));
    st_c   = (first | st_ok) & (!in_da | (rx_data == st_b));
    ctl_c  = (first | ctl_ok) & (!in_ctl | (rx_data == mc_b));
    vh_c   = (idx == 5'd16) ? rx_data : val_hi;
    vl_c   = (idx == 5'd17) ? rx_data : val_lo;
    accept = rx_en & rx_valid & rx_last & rx_fcs_ok & (mc_c | st_c) & ctl_c &
             (idx >= 5'd17);
    accept_val = {vh_c, vl_c};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      mc_ok     <= 1'b0;
      st_ok     <= 1'b0;
      ctl_ok    <= 1'b0;
      val_hi    <= '0;
      val_lo    <= '0;
      pause_bad <= 1'b0;
    end else begin
      pause_bad <= accept;
      if (rx_valid) begin
        mc_ok  <= mc_c;
        st_ok  <= st_c;
        ctl_ok <= ctl_c;
        val_hi <= vh_c;
        val_lo <= vl_c;
        if (rx_last)             idx <= '0;
        else if (idx != IDX_SAT) idx <= idx + 1'b1;
      end
    end
  end

  // R5: the bad flag is a single-cycle pulse
  p_flag_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pause_bad |=> !pause_bad);
  // R5: a flag always follows the last byte of a frame
  p_flag_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pause_bad |-> $past(rx_valid && rx_last));
endmodule

// File: rtl/fc_pause_tx.sv
module fc_pause_tx
  import fc_pause_pkg::*;
#(
  parameter int FRAME_BYTES = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             req,
  input  logic [VAL_W-1:0] req_val,
  input  logic             tx_busy,
  input  logic [47:0]      sa,
  input  logic             pf_ready,
  output logic             pf_valid,
  output logic [7:0]       pf_data,
  output logic             pf_last
);
  localparam int IDX_W = $clog2(FRAME_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES - 1);

  tx_state_e        state;
  logic             pend;
  logic [VAL_W-1:0] pend_val, send_val;
  logic [IDX_W-1:0] idx;
  logic             take, start;

  assign take  = req & tx_en;
  assign start = (state == TX_IDLE) & pend & ~tx_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      pend     <= 1'b0;
      pend_val <= '0;
      send_val <= '0;
      idx      <= '0;
    end else begin
      if (take)       pend <= 1'b1;
      else if (start) pend <= 1'b0;
      if (take)  pend_val <= req_val;
      if (start) begin
        send_val <= pend_val;
        idx      <= '0;
        state    <= TX_SEND;
      end else if (state == TX_SEND && pf_ready) begin
        if (idx == IDX_LAST) state <= TX_IDLE;
        else                 idx   <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    pf_valid = (state == TX_SEND);
    pf_data  = hdr_byte(6'(idx), CTRL_MCAST, sa, send_val);
    pf_last  = pf_valid && (idx == IDX_LAST);
  end

  // R4: stalled output holds
  p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_data) && $stable(pf_last)));
  // R3: no frame starts while the MAC is busy
  p_wait_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pf_valid && tx_busy) |=> !pf_valid);
  // R2: the frame ends after its last byte is taken
  p_end_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready && pf_last) |=> !pf_valid);
endmodule

// File: rtl/fc_pause_unit.sv
module fc_pause_unit
  import fc_pause_pkg::*;
#(
  parameter int QUANTUM_CYC = 64,
  parameter int FRAME_BYTES = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_tx_fc_en,
  input  logic        cfg_rx_fc_en,
  input  logic [47:0] station_addr,
  input  logic        pause_req,
  input  logic [15:0] pause_val,
  input  logic        tx_busy,
  output logic        pf_valid,
  input  logic        pf_ready,
  output logic [7:0]  pf_data,
  output logic        pf_last,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic        rx_fcs_ok,
  output logic        rx_pause_bad,
  output logic        tx_inhibit
);
  logic             tx_en_q, rx_en_q;
  logic             accept;
  logic [VAL_W-1:0] accept_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en_q <= 1'b1;
      rx_en_q <= 1'b1;
    end else if (cfg_we) begin
      tx_en_q <= cfg_tx_fc_en;
      rx_en_q <= cfg_rx_fc_en;
    end
  end

  fc_pause_tx #(.FRAME_BYTES(FRAME_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en_q), .req(pause_req), .req_val(pause_val),
    .tx_busy(tx_busy), .sa(station_addr), .pf_ready(pf_ready), .pf_valid(pf_valid),
    .pf_data(pf_data), .pf_last(pf_last));

  fc_pause_rx u_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en_q), .station_addr(station_addr),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_fcs_ok(rx_fcs_ok),
    .accept(accept), .accept_val(accept_val), .pause_bad(rx_pause_bad));

  fc_pause_timer #(.QUANTUM_CYC(QUANTUM_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(accept_val), .inhibit(tx_inhibit));

  // R9: receive side disabled means no flag
  p_no_flag_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_q |=> !rx_pause_bad);
  // R9: inhibit cannot rise without a flagged frame
  p_inhibit_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_inhibit) |-> rx_pause_bad);
endmodule

// File: tb/tb_fc_pause_unit.sv
module tb_fc_pause_unit;
  localparam int CLK_PERIOD = 10;
  localparam int QUANTUM = 64;
  localparam logic [47:0] STATION = 48'hFFEEDDCCBBAA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_tx_fc_en = 1, cfg_rx_fc_en = 1;
  logic pause_req = 0, tx_busy = 0, pf_ready = 0;
  logic [15:0] pause_val = '0;
  logic rx_valid = 0, rx_last = 0, rx_fcs_ok = 0;
  logic [7:0] rx_data = '0;
  logic pf_valid, pf_last, rx_pause_bad, tx_inhibit;
  logic [7:0] pf_data;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_pause_unit #(.QUANTUM_CYC(QUANTUM)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tx_fc_en(cfg_tx_fc_en),
    .cfg_rx_fc_en(cfg_rx_fc_en), .station_addr(STATION), .pause_req(pause_req),
    .pause_val(pause_val), .tx_busy(tx_busy), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_data(pf_data), .pf_last(pf_last), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_fcs_ok(rx_fcs_ok), .rx_pause_bad(rx_pause_bad),
    .tx_inhibit(tx_inhibit));

  typedef struct packed {
    logic [1:0]  da_sel;   // 0 control multicast, 1 station, 2 foreign
    logic [15:0] typ;
    logic [15:0] opc;
    logic        fcs;
    logic [15:0] val;
    logic [7:0]  len;
    logic        exp_bad;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 16'h8808, 16'h0001, 1'b1, 16'd1, 8'd64, 1'b1},
    '{2'd1, 16'h8808, 16'h0001, 1'b1, 16'd2, 8'd64, 1'b1},
    '{2'd2, 16'h8808, 16'h0001, 1'b1, 16'd1, 8'd64, 1'b0},
    '{2'd0, 16'h0800, 16'h0001, 1'b1, 16'd1, 8'd64, 1'b0},
    '{2'd0, 16'h8808, 16'h0002, 1'b1, 16'd1, 8'd64, 1'b0},
    '{2'd0, 16'h8808, 16'h0001, 1'b0, 16'd1, 8'd64, 1'b0},
    '{2'd0, 16'h8808, 16'h0001, 1'b1, 16'd1, 8'd17, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] wire_byte(input int i, input logic [1:0] da_sel,
      input logic [15:0] typ, input logic [15:0] opc, input logic [15:0] val);
    logic [47:0] da;
    case (da_sel)
      2'd0:    da = 48'h01_00_00_C2_80_01;
      2'd1:    da = STATION;
      default: da = 48'h665544332211;
    endcase
    if (i < 6)       return da[8*i +: 8];
    else if (i < 12) return STATION[8*(i-6) +: 8];
    else if (i == 12) return typ[15:8];
    else if (i == 13) return typ[7:0];
    else if (i == 14) return opc[15:8];
    else if (i == 15) return opc[7:0];
    else if (i == 16) return val[15:8];
    else if (i == 17) return val[7:0];
    return 8'h5A;
  endfunction

  task automatic send_rx(input logic [1:0] da_sel, input logic [15:0] typ,
      input logic [15:0] opc, input logic fcs, input logic [15:0] val, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid  = 1'b1;
      rx_data   = wire_byte(i, da_sel, typ, opc, val);
      rx_last   = (i == len - 1);
      rx_fcs_ok = fcs;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
  endtask

  task automatic measure_inhibit(output int n);
    n = 0;
    while (tx_inhibit && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic cfg(input logic txe, input logic rxe);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tx_fc_en = txe; cfg_rx_fc_en = rxe;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_req(input logic [15:0] v);
    @(negedge clk);
    pause_req = 1'b1; pause_val = v;
    @(negedge clk);
    pause_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pf_valid, "R1", "pf_valid after reset", pf_valid, 0);
    chk(!tx_inhibit, "R1", "tx_inhibit after reset", tx_inhibit, 0);
    chk(!rx_pause_bad, "R1", "rx_pause_bad after reset", rx_pause_bad, 0);

    // Table walk; first vector also relies on the R1 default receive enable
    for (int v = 0; v < NVEC; v++) begin
      send_rx(VECS[v].da_sel, VECS[v].typ, VECS[v].opc, VECS[v].fcs, VECS[v].val,
              int'(VECS[v].len));
      chk(rx_pause_bad == VECS[v].exp_bad, "R5", $sformatf("flag vector %0d", v),
          rx_pause_bad, VECS[v].exp_bad);
      measure_inhibit(n);
      chk(n == (VECS[v].exp_bad ? int'(VECS[v].val) * QUANTUM : 0), "R6",
          $sformatf("inhibit length vector %0d", v), n,
          VECS[v].exp_bad ? int'(VECS[v].val) * QUANTUM : 0);
      repeat (3) @(negedge clk);
    end

    // R7: reload replaces remaining time
    send_rx(2'd0, 16'h8808, 16'h0001, 1'b1, 16'd10, 64);
    repeat (100) @(negedge clk);
    send_rx(2'd0, 16'h8808, 16'h0001, 1'b1, 16'd2, 64);
    measure_inhibit(n);
    chk(n == 2 * QUANTUM, "R7", "inhibit after reload", n, 2 * QUANTUM);

    // R8: zero clears a pause in progress
    send_rx(2'd0, 16'h8808, 16'h0001, 1'b1, 16'd10, 64);
    repeat (20) @(negedge clk);
    send_rx(2'd0, 16'h8808, 16'h0001, 1'b1, 16'd0, 64);
    chk(rx_pause_bad, "R8", "zero frame flagged", rx_pause_bad, 1);
    chk(!tx_inhibit, "R8", "inhibit cleared by zero", tx_inhibit, 0);

    // R9 / R11: receive disabled, then re-enabled
    cfg(1'b1, 1'b0);
    send_rx(2'd0, 16'h8808, 16'h0001, 1'b1, 16'd3, 64);
    chk(!rx_pause_bad, "R9", "flag while disabled", rx_pause_bad, 0);
    chk(!tx_inhibit, "R9", "inhibit while disabled", tx_inhibit, 0);
    cfg(1'b1, 1'b1);
    send_rx(2'd0, 16'h8808, 16'h0001, 1'b1, 16'd1, 64);
    chk(rx_pause_bad, "R11", "flag after re-enable", rx_pause_bad, 1);
    measure_inhibit(n);

    // R3: request waits for busy to fall
    tx_busy = 1'b1;
    pulse_req(16'h1234);
    seen = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (pf_valid) seen = 1;
    end
    chk(!seen, "R3", "frame started while busy", seen, 0);
    tx_busy = 1'b0;

    // R2 / R4: collect the frame with ready toggling
    begin
      int got = 0;
      int badlast = 0;
      logic [7:0] held;
      bit stalled = 0;
      for (int c = 0; c < 400 && got < 60; c++) begin
        @(negedge clk);
        if (stalled) begin
          chk(pf_valid && pf_data == held, "R4", "stalled byte held", pf_data, held);
        end
        pf_ready = c[0];
        stalled = pf_valid && !pf_ready;
        held = pf_data;
        if (pf_valid && pf_ready) begin
          chk(pf_data == wire_byte(got, 2'd0, 16'h8808, 16'h0001,
                                   (got < 18) ? 16'h1234 : 16'h0) ||
              (got >= 18 && pf_data == 8'h00), "R2",
              $sformatf("byte %0d", got), pf_data,
              (got >= 18) ? 8'h00 : wire_byte(got, 2'd0, 16'h8808, 16'h0001, 16'h1234));
          if (pf_last != (got == 59)) badlast++;
          got++;
        end
      end
      chk(got == 60, "R2", "byte count", got, 60);
      chk(badlast == 0, "R2", "pf_last placement errors", badlast, 0);
      @(negedge clk);
      pf_ready = 1'b0;
      chk(!pf_valid, "R2", "no second frame", pf_valid, 0);
    end

    // R10: transmit disabled ignores requests
    cfg(1'b0, 1'b1);
    pf_ready = 1'b1;
    pulse_req(16'h0042);
    seen = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (pf_valid) seen = 1;
    end
    chk(!seen, "R10", "frame while transmit disabled", seen, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule